// File: doc/BRIEF.md
# Dual-Edge First/Last Crossing Timestamp Averager

This block times a slow, noisy falling input that arrives without any hysteresis. After it is armed, it samples the input on both clock edges. It latches the timestamp of the first high-to-low change as a fixed reference, and it keeps updating a second timestamp with every later change until a window-end pulse closes the measurement. When the window closes, it reports the mean of the two timestamps. Chatter around the threshold then biases the result toward the centre of the noisy region and not toward its first edge.

Timestamps are in half-clock units. The integer part comes from a free-running count supplied on `ts_i`. The least significant bit says which clock edge took the sample. The average keeps one fractional bit, so odd sums are not rounded. A measurement that sees no falling change reports a no-crossing flag and no valid flag.

Top module: `xcap_averager`

## Requirements
- R1: The first high-to-low change seen after arming sets `first_o`; no later change in the same window alters it.
- R2: Once the first fall is latched, `last_o` follows the stamp of the most recent change in either direction. While no fall has been latched, `last_o` equals `first_o`.
- R3: A sample taken at a rising edge has stamp 2·T, and the sample at the following falling edge has stamp 2·T+1, where T is the `ts_i` value registered at that rising edge. A change is stamped with the first sample that shows the new level.
- R4: When valid, `avg_o` equals `first_o + last_o`. This is the mean in half-clock units with `avg_o[0]` as a single fractional bit (weight one half).
- R5: At the window-end edge the result registers update. From that edge on, `valid_o` is 1 if a fall was latched, and `nocross_o` is 1 otherwise. Both hold until the next arm.
- R6: When `arm_i` is high at rising edge k, the window covers the samples from edge k onward. When `win_end_i` is high at rising edge K, the window covers the samples up to and including the falling edge just before K. A fall at the first sample is detected against the sample taken just before arming.
- R7: Reset and arming both clear the timestamps, the average and both flags. When `arm_i` and `win_end_i` are high at the same edge, arming wins and the window stays open.
- R8: `win_end_i` while not armed is ignored: all outputs keep their values.
- R9: Rising changes before the first fall are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; both edges sample `sig_i` |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Start a new measurement, clearing all results |
| ts_i | input | TS_W | Free-running timestamp count, one step per clock |
| sig_i | input | 1 | Raw threshold input (no hysteresis) |
| win_end_i | input | 1 | Close the current measurement window |
| first_o | output | TS_W+1 | Stamp of first fall, half-clock units |
| last_o | output | TS_W+1 | Stamp of most recent change, half-clock units |
| avg_o | output | TS_W+2 | Mean of first and last, one fractional bit |
| valid_o | output | 1 | Window closed with a crossing found |
| nocross_o | output | 1 | Window closed with no crossing |

## Verification
A wrong first-fall latch or last-change tracker shows up in `first_o` or `last_o` at the window-end edge of the same measurement. A mistake in merging the two edge domains moves a stamp by exactly one half-clock unit, which turns the parity of `first_o` or `last_o` wrong in the first window that contains a falling-edge change. Sweeping every 8-sample pattern with both pre-arm levels reaches every pairing of even and odd stamps, so an error in the ordering or in the edge priority shows up within one window. A flag or clear fault appears in the window right after the arm or the idle pulse that triggers it.

// File: rtl/xcap_pkg.sv
package xcap_pkg;
  // samples available at one rising edge, oldest first
  typedef struct packed {
    logic prev;   // last sample of the previous pair (falling edge)
    logic s_pos;  // rising-edge sample, stamp 2T
    logic s_neg;  // following falling-edge sample, stamp 2T+1
  } lvl_t;
endpackage

// File: rtl/xcap_dual_sampler.sv
module xcap_dual_sampler
  import xcap_pkg::*;
#(
  parameter int TS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sig_i,
  input  logic [TS_W-1:0] ts_i,
  output lvl_t            lvl_o,
  output logic [TS_W-1:0] base_o
);
  logic            pos_q, neg_q, prev_q;
  logic [TS_W-1:0] ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= 1'b0;
      ts_q  <= '0;
    end else begin
      pos_q <= sig_i;
      ts_q  <= ts_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= sig_i;
  end

  // falling-edge sample is consumed only in the rising domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= neg_q;
  end

  assign lvl_o  = '{prev: prev_q, s_pos: pos_q, s_neg: neg_q};
  assign base_o = ts_q;
endmodule

// File: rtl/xcap_tracker.sv
module xcap_tracker
  import xcap_pkg::*;
#(
  parameter int TS_W = 16,
  localparam int SW  = TS_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  input  logic            win_end_i,
  input  lvl_t            lvl_i,
  input  logic [TS_W-1:0] base_i,
  output logic [SW-1:0]   first_o,
  output logic [SW-1:0]   last_o,
  output logic [SW-1:0]   first_nxt_o,
  output logic [SW-1:0]   last_nxt_o,
  output logic            close_o,
  output logic            valid_o,
  output logic            nocross_o
);
  logic          active_q, found_q, done_q;
  logic [SW-1:0] first_q, last_q;
  logic [SW-1:0] f_n, l_n, st_e, st_o;
  logic          fd_n, fall_e, fall_o, chg_e, chg_o;

  assign st_e   = {base_i, 1'b0};
  assign st_o   = {base_i, 1'b1};
  assign fall_e = lvl_i.prev & ~lvl_i.s_pos;
  assign fall_o = lvl_i.s_pos & ~lvl_i.s_neg;
  assign chg_e  = lvl_i.prev ^ lvl_i.s_pos;
  assign chg_o  = lvl_i.s_pos ^ lvl_i.s_neg;

  always_comb begin
    f_n  = first_q;
    l_n  = last_q;
    fd_n = found_q;
    if (active_q) begin
      if (!found_q) begin
        if (fall_e) begin
          fd_n = 1'b1;
          f_n  = st_e;
          l_n  = chg_o ? st_o : st_e;
        end else if (fall_o) begin
          fd_n = 1'b1;
          f_n  = st_o;
          l_n  = st_o;
        end
      end else if (chg_o) begin
        l_n = st_o;
      end else if (chg_e) begin
        l_n = st_e;
      end
    end
  end

  assign close_o = active_q & win_end_i & ~arm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      found_q  <= 1'b0;
      done_q   <= 1'b0;
      first_q  <= '0;
      last_q   <= '0;
    end else if (arm_i) begin
      active_q <= 1'b1;
      found_q  <= 1'b0;
      done_q   <= 1'b0;
      first_q  <= '0;
      last_q   <= '0;
    end else begin
      found_q <= fd_n;
      first_q <= f_n;
      last_q  <= l_n;
      if (close_o) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  assign first_o     = first_q;
  assign last_o      = last_q;
  assign first_nxt_o = f_n;
  assign last_nxt_o  = l_n;
  assign valid_o     = done_q & found_q;
  assign nocross_o   = done_q & ~found_q;

  AST_FIRST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_q && !arm_i) |=> $stable(first_q)); // R1
  AST_LAST_AFTER_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_q |-> (last_q >= first_q)); // R2
  AST_ARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!found_q && !done_q && first_q == '0 && last_q == '0)); // R7
  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !arm_i) |=> ($stable(first_q) && $stable(last_q) && $stable(done_q))); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !arm_i) |=> (done_q && $stable(found_q))); // R5
endmodule

// File: rtl/xcap_avg.sv
module xcap_avg #(
  parameter int SW  = 17,
  localparam int AW = SW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          close_i,
  input  logic [SW-1:0] first_i,
  input  logic [SW-1:0] last_i,
  output logic [AW-1:0] avg_o
);
  logic [AW-1:0] sum_q;

  // sum of two half-unit stamps == mean with one fractional bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sum_q <= '0;
    else if (arm_i)   sum_q <= '0;
    else if (close_i) sum_q <= AW'(first_i) + AW'(last_i);
  end

  assign avg_o = sum_q;

  AST_SUM_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (sum_q == '0)); // R7
endmodule

// File: rtl/xcap_averager.sv
module xcap_averager
  import xcap_pkg::*;
#(
  parameter int TS_W = 16,
  localparam int SW  = TS_W + 1,
  localparam int AW  = SW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  input  logic [TS_W-1:0] ts_i,
  input  logic            sig_i,
  input  logic            win_end_i,
  output logic [SW-1:0]   first_o,
  output logic [SW-1:0]   last_o,
  output logic [AW-1:0]   avg_o,
  output logic            valid_o,
  output logic            nocross_o
);
  lvl_t            lvl;
  logic [TS_W-1:0] base;
  logic [SW-1:0]   f_nxt, l_nxt;
  logic            close;

  xcap_dual_sampler #(.TS_W(TS_W)) u_smp (
    .clk_i, .rst_ni, .sig_i, .ts_i,
    .lvl_o  (lvl),
    .base_o (base)
  );

  xcap_tracker #(.TS_W(TS_W)) u_trk (
    .clk_i, .rst_ni, .arm_i, .win_end_i,
    .lvl_i       (lvl),
    .base_i      (base),
    .first_o     (first_o),
    .last_o      (last_o),
    .first_nxt_o (f_nxt),
    .last_nxt_o  (l_nxt),
    .close_o     (close),
    .valid_o     (valid_o),
    .nocross_o   (nocross_o)
  );

  xcap_avg #(.SW(SW)) u_avg (
    .clk_i, .rst_ni, .arm_i,
    .close_i (close),
    .first_i (f_nxt),
    .last_i  (l_nxt),
    .avg_o   (avg_o)
  );

  AST_AVG_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (avg_o >= {first_o, 1'b0} && avg_o <= {last_o, 1'b0})); // R4
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && nocross_o)); // R5
endmodule

// File: tb/xcap_averager_test.sv
module xcap_averager_test;
  localparam int TS_W = 16;
  localparam int SW   = TS_W + 1;
  localparam int AW   = SW + 1;

  logic            clk_i = 1'b0, rst_ni = 1'b0;
  logic            arm_i = 1'b0, sig_i = 1'b1, win_end_i = 1'b0;
  logic [TS_W-1:0] ts_i = '0;
  logic [SW-1:0]   first_o, last_o;
  logic [AW-1:0]   avg_o;
  logic            valid_o, nocross_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  xcap_averager #(.TS_W(TS_W)) uut (.*);

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) ts_i <= ts_i + 1'b1;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [31:0] ef, el, ea,
                         input logic ev, en);
    chk(req, "first_o", 32'(first_o), ef);
    chk(req, "last_o", 32'(last_o), el);
    chk(req, "avg_o", 32'(avg_o), ea);
    chk(req, "valid_o", 32'(valid_o), 32'(ev));
    chk(req, "nocross_o", 32'(nocross_o), 32'(en));
  endtask

  // entered just after a falling edge; leaves just after a falling edge
  task automatic run_case(input logic pre, input logic [7:0] pat);
    logic [31:0] s0, ef, el;
    logic found, p;
    sig_i = pre;
    @(posedge clk_i); #1;
    @(negedge clk_i); #1;       // this falling edge sampled pre
    s0 = 32'(ts_i) * 2;         // ts registered at the arming rising edge (R3)
    arm_i = 1'b1;
    sig_i = pat[0];
    for (int h = 1; h < 8; h++) begin
      if ((h - 1) % 2 == 0) @(posedge clk_i); else @(negedge clk_i);
      #1;
      arm_i = 1'b0;
      sig_i = pat[h];
    end
    @(negedge clk_i); #1;       // sample 7 taken
    win_end_i = 1'b1;
    @(posedge clk_i); #1;
    win_end_i = 1'b0;
    found = 1'b0; ef = 0; el = 0;
    for (int h = 0; h < 8; h++) begin
      p = (h == 0) ? pre : pat[h-1];
      if (!found) begin
        if (p && !pat[h]) begin found = 1'b1; ef = s0 + 32'(h); el = ef; end  // R1 R9
      end else if (p != pat[h]) el = s0 + 32'(h);                            // R2 R3
    end
    if (found) chk_all("R1/R2/R3/R4/R6", ef, el, ef + el, 1'b1, 1'b0);
    else       chk_all("R5/R9", 0, 0, 0, 1'b0, 1'b1);
    @(negedge clk_i); #1;
  endtask

  initial begin
    logic [31:0] kf, kl, ka;
    repeat (3) @(negedge clk_i);
    #1;
    chk_all("R7 reset", 0, 0, 0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    #1;

    // exhaustive 8-sample sweep, both pre-arm levels
    for (int pre = 0; pre < 2; pre++)
      for (int p = 0; p < 256; p++)
        run_case(pre[0], p[7:0]);

    // R8: window-end while idle keeps results
    run_case(1'b1, 8'b1111_0000);
    kf = 32'(first_o); kl = 32'(last_o); ka = 32'(avg_o);
    win_end_i = 1'b1;
    @(posedge clk_i); #1;
    win_end_i = 1'b0;
    sig_i = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i); #1;
    chk_all("R8 idle win_end", kf, kl, ka, 1'b1, 1'b0);

    // R7: arming clears results
    arm_i = 1'b1;
    @(posedge clk_i); #1;
    arm_i = 1'b0;
    @(negedge clk_i); #1;
    chk_all("R7 arm clear", 0, 0, 0, 1'b0, 1'b0);

    // R7: arm with win_end together keeps window open
    sig_i = 1'b1;
    @(posedge clk_i); #1;
    @(negedge clk_i); #1;
    arm_i = 1'b1; win_end_i = 1'b1;
    @(posedge clk_i); #1;
    arm_i = 1'b0; win_end_i = 1'b0;
    @(negedge clk_i); #1;
    chk_all("R7 arm priority", 0, 0, 0, 1'b0, 1'b0);
    kf = 32'(ts_i) * 2;          // stamp of the next rising-edge sample
    sig_i = 1'b0;
    @(posedge clk_i); #1;
    @(negedge clk_i); #1;
    win_end_i = 1'b1;
    @(posedge clk_i); #1;
    win_end_i = 1'b0;
    chk_all("R7 window kept open", kf, kf, 2 * kf, 1'b1, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule